// File: doc/BRIEF.md
# Sampling Converter Host Interface Sequencer

This block is the digital front end of a 10-bit two-step sampling converter. It watches three active-low host strobes: chip select, sample/hold and read. A free-running clock times the internal phases. The block drives the phase enables for the analog section: a tracking/coarse enable and a fine enable. It captures the coarse and fine codes that the decoder supplies, and presents the assembled result on a data bus with an output-enable. At the end of every conversion it pulls an active-low interrupt low.

There are two start modes. In strobed-start mode (`mode_rd` = 0), the sample/hold strobe going low begins tracking. Its rising edge ends the coarse phase, latches the coarse code and begins a fine phase of fixed length. In read-start mode (`mode_rd` = 1), the sample/hold and read strobes are tied together. Pulling them low starts a timed coarse phase followed by the fine phase. The bus is enabled for the whole conversion, but it carries the previous result until the interrupt falls.

All strobes pass through a `SYNC_STAGES`-deep synchronizer. Every latency below counts clock edges after the strobe changes, with the default of 2 stages, `COARSE_CYC` = 12, `FINE_CYC` = 10 and `RECOV_CYC` = 4.

Top module: `adc_busif`

## Requirements
- R1: After reset, `int_n` is 1, `db_oe` is 0, `trk_o` and `fine_o` are 0, and `db_out` is 0.
- R2: While `cs_n` is 1, the `sh_n` and `rd_n` strobes have no effect: `trk_o` and `db_oe` stay 0.
- R3: In strobed-start mode, `trk_o` rises on the 3rd edge after `cs_n`&`sh_n` go low. It stays high for as many cycles as the strobe was held low. `int_n` falls on edge 3+`FINE_CYC` after `sh_n` rises.
- R4: In read-start mode, `int_n` falls on edge 3+`COARSE_CYC`+`FINE_CYC` after the tied strobes go low, and `trk_o` is high for exactly `COARSE_CYC` cycles.
- R5: When `int_n` falls, `db_out` holds the result. Bits [9:4] are the coarse code present at the end of the coarse phase. Bits [3:0] are the fine code present at the end of the fine phase.
- R6: `int_n` stays low until the read strobe (qualified by chip select) is released. It returns to 1 on the 3rd edge after that release, and a held-low read does not clear it.
- R7: `db_oe` rises on the 3rd edge after `cs_n`&`rd_n` go low and falls on the 3rd edge after release.
- R8: In read-start mode, during the conversion `db_oe` is 1 and `db_out` still shows the previous result.
- R9: A sample/hold start arriving during the fine phase is ignored: timing and result are unchanged and `trk_o` stays 0.
- R10: For `RECOV_CYC` cycles after `int_n` falls, a new start is ignored (`trk_o` stays 0). A start after that window is accepted.
- R11: `fine_o` is high for exactly `FINE_CYC` cycles per conversion, and `trk_o` and `fine_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running phase timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rd | input | 1 | 0 strobed-start, 1 read-start (strobes tied) |
| cs_n | input | 1 | Active-low chip select, qualifies both strobes |
| sh_n | input | 1 | Active-low sample/hold strobe |
| rd_n | input | 1 | Active-low read strobe |
| coarse_code | input | 6 | Coarse code from the decoder |
| fine_code | input | 4 | Fine code from the decoder |
| trk_o | output | 1 | Tracking / coarse comparison enable |
| fine_o | output | 1 | Fine comparison enable |
| int_n | output | 1 | Active-low end-of-conversion interrupt |
| db_out | output | 10 | Result data bus |
| db_oe | output | 1 | Data bus output enable |

## Verification
The hardest situation to reach from the ports is a start strobe that lands inside the recovery window or inside the fine phase. The synchronizer shifts every strobe by a fixed number of edges. To hit these windows, the bench injects one-cycle sample/hold pulses at chosen edge offsets counted from the release of the strobe or from the fall of the interrupt. It then checks that `trk_o` stays low and that both the interrupt timing and the result are unchanged. Latching is checked by changing the decoder codes right after each phase boundary, so that a late capture would show up in `db_out`.

// File: rtl/adc_busif_pkg.sv
package adc_busif_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_COARSE,
        PH_FINE,
        PH_RECOV
    } phase_e;
endpackage

// File: rtl/adc_busif_sync.sv
module adc_busif_sync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    assign chain_d[0] = din;
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        assign chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/adc_busif_seq.sv
module adc_busif_seq
    import adc_busif_pkg::*;
#(
    parameter int COARSE_W   = 6,
    parameter int FINE_W     = 4,
    parameter int COARSE_CYC = 12,
    parameter int FINE_CYC   = 10,
    parameter int RECOV_CYC  = 4,
    localparam int DATA_W    = COARSE_W + FINE_W,
    localparam int MAX_A     = (COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC,
    localparam int MAX_CYC   = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC,
    localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_rd,
    input  logic                start_lvl,
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic [FINE_W-1:0]   fine_code,
    output logic                trk_o,
    output logic                fine_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   result_o
);
    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic                start_prev;
        logic [COARSE_W-1:0] coarse;
        logic [DATA_W-1:0]   result;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start_edge;
    logic cnt_zero;

    localparam logic [CNT_W-1:0] COARSE_LD = CNT_W'(COARSE_CYC - 1);
    localparam logic [CNT_W-1:0] FINE_LD   = CNT_W'(FINE_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD  = CNT_W'(RECOV_CYC - 1);

    always_comb begin
        seq_d            = seq_q;
        seq_d.start_prev = start_lvl;
        start_edge       = start_lvl & ~seq_q.start_prev;
        cnt_zero         = (seq_q.cnt == '0);
        done_o           = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_edge) begin
                    if (mode_rd) begin
                        seq_d.phase = PH_COARSE;
                        seq_d.cnt   = COARSE_LD;
                    end else begin
                        seq_d.phase = PH_SAMPLE;
                    end
                end
            end
            PH_SAMPLE: begin
                if (!start_lvl) begin
                    seq_d.coarse = coarse_code;
                    seq_d.phase  = PH_FINE;
                    seq_d.cnt    = FINE_LD;
                end
            end
            PH_COARSE: begin
                if (cnt_zero) begin
                    seq_d.coarse = coarse_code;
                    seq_d.phase  = PH_FINE;
                    seq_d.cnt    = FINE_LD;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_FINE: begin
                if (cnt_zero) begin
                    done_o       = 1'b1;
                    seq_d.result = {seq_q.coarse, fine_code};
                    seq_d.phase  = PH_RECOV;
                    seq_d.cnt    = RECOV_LD;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_RECOV: begin
                if (cnt_zero) seq_d.phase = PH_IDLE;
                else          seq_d.cnt   = seq_q.cnt - 1'b1;
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, cnt: '0, start_prev: 1'b0,
                       coarse: '0, result: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign trk_o    = (seq_q.phase == PH_SAMPLE) || (seq_q.phase == PH_COARSE);
    assign fine_o   = (seq_q.phase == PH_FINE);
    assign result_o = seq_q.result;

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_FINE) |=> (seq_q.phase == PH_FINE || seq_q.phase == PH_RECOV));

    // R11
    fine_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_FINE) |-> (seq_q.cnt < CNT_W'(FINE_CYC)));

    // R10
    recov_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_RECOV) |=> (seq_q.phase == PH_RECOV || seq_q.phase == PH_IDLE));

    // R11
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trk_o, fine_o}));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done_o) |-> $stable(result_o));
endmodule

// File: rtl/adc_busif_out.sv
module adc_busif_out (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_lvl,
    input  logic done_i,
    output logic int_n_o,
    output logic oe_o
);
    typedef struct packed {
        logic int_n;
        logic oe;
        logic rd_prev;
    } out_t;

    out_t out_d, out_q;
    logic rd_release;

    always_comb begin
        out_d         = out_q;
        rd_release    = out_q.rd_prev & ~rd_lvl;
        out_d.rd_prev = rd_lvl;
        out_d.oe      = rd_lvl;
        if (done_i)          out_d.int_n = 1'b0;
        else if (rd_release) out_d.int_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{int_n: 1'b1, oe: 1'b0, rd_prev: 1'b0};
        else        out_q <= out_d;
    end

    assign int_n_o = out_q.int_n;
    assign oe_o    = out_q.oe;

    // R6
    int_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q.int_n) |-> $past(done_i));

    // R6
    int_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q.int_n) |-> !$past(rd_lvl));

    // R7
    oe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.oe |-> $past(rd_lvl));
endmodule

// File: rtl/adc_busif.sv
module adc_busif #(
    parameter int COARSE_W    = 6,
    parameter int FINE_W      = 4,
    parameter int COARSE_CYC  = 12,
    parameter int FINE_CYC    = 10,
    parameter int RECOV_CYC   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_rd,
    input  logic                cs_n,
    input  logic                sh_n,
    input  logic                rd_n,
    input  logic [COARSE_W-1:0] coarse_code,
    input  logic [FINE_W-1:0]   fine_code,
    output logic                trk_o,
    output logic                fine_o,
    output logic                int_n,
    output logic [DATA_W-1:0]   db_out,
    output logic                db_oe
);
    logic [2:0] strobe_s;
    logic       sh_act;
    logic       rd_act;
    logic       done;

    adc_busif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sh_n, rd_n}),
        .dout (strobe_s)
    );

    assign sh_act = ~strobe_s[2] & ~strobe_s[1];
    assign rd_act = ~strobe_s[2] & ~strobe_s[0];

    adc_busif_seq #(
        .COARSE_W  (COARSE_W),
        .FINE_W    (FINE_W),
        .COARSE_CYC(COARSE_CYC),
        .FINE_CYC  (FINE_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_rd    (mode_rd),
        .start_lvl  (sh_act),
        .coarse_code(coarse_code),
        .fine_code  (fine_code),
        .trk_o      (trk_o),
        .fine_o     (fine_o),
        .done_o     (done),
        .result_o   (db_out)
    );

    adc_busif_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_lvl (rd_act),
        .done_i (done),
        .int_n_o(int_n),
        .oe_o   (db_oe)
    );

    // R2
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trk_o) |-> $past(sh_act));
endmodule

// File: tb/adc_busif_tb.sv
module adc_busif_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CC = 12;
    localparam int FC = 10;
    localparam int RC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rd = 1'b0;
    logic       cs_n = 1'b0;
    logic       sh_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [5:0] coarse_code = '0;
    logic [3:0] fine_code = '0;
    logic       trk_o, fine_o, int_n, db_oe;
    logic [9:0] db_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_busif #(.COARSE_CYC(CC), .FINE_CYC(FC), .RECOV_CYC(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_rd(mode_rd), .cs_n(cs_n), .sh_n(sh_n),
        .rd_n(rd_n), .coarse_code(coarse_code), .fine_code(fine_code),
        .trk_o(trk_o), .fine_o(fine_o), .int_n(int_n), .db_out(db_out), .db_oe(db_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(int_n == 1'b1, "R1 int_n", int_n, 1);
        chk(db_oe == 1'b0, "R1 db_oe", db_oe, 0);
        chk(trk_o == 1'b0 && fine_o == 1'b0, "R1 phases", {trk_o, fine_o}, 0);
        chk(db_out == 10'd0, "R1 db_out", db_out, 0);
    endtask

    task automatic t_cs_gate();
        int bad = 0;
        cs_n = 1'b1; sh_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (trk_o || db_oe) bad++;
        end
        sh_n = 1'b1; rd_n = 1'b1;
        repeat (4) tick();
        cs_n = 1'b0;
        repeat (4) tick();
        chk(bad == 0, "R2 strobes ignored without chip select", bad, 0);
        chk(trk_o == 1'b0 && int_n == 1'b1, "R2 idle after gated strobes", trk_o, 0);
    endtask

    // strobed-start conversion; inject: pulse sh during fine phase
    task automatic t_mode1(input logic [5:0] c, input logic [3:0] f, input int hold, input bit inject);
        int trk_n = 0;
        int fine_n = 0;
        int n = 0;
        mode_rd = 1'b0;
        coarse_code = c; fine_code = f;
        sh_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            tick();
            if (trk_o) trk_n++;
            if (i == 2) chk(trk_o == 1'b1, "R3 trk rises on edge 3", trk_o, 1);
            if (i == 1) chk(trk_o == 1'b0, "R3 trk low before edge 3", trk_o, 0);
        end
        sh_n = 1'b1;
        while (n < 100) begin
            tick();
            n++;
            if (trk_o) trk_n++;
            if (fine_o) begin
                fine_n++;
                coarse_code = ~c;
            end
            if (inject && n == 5) sh_n = 1'b0;
            if (inject && n == 6) sh_n = 1'b1;
            if (!int_n) break;
        end
        if (inject) begin
            chk(n == 3 + FC, "R9 int timing with start during fine phase", n, 3 + FC);
            chk(trk_n == hold, "R9 no tracking from ignored start", trk_n, hold);
        end else begin
            chk(n == 3 + FC, "R3 int falls 3+FINE edges after release", n, 3 + FC);
            chk(trk_n == hold, "R3 trk length equals hold", trk_n, hold);
        end
        chk(fine_n == FC, "R11 fine phase length", fine_n, FC);
        chk(db_out == {c, f}, "R5 result assembled", db_out, {c, f});
        fine_code = ~f;
    endtask

    task automatic t_read_clear(input logic [9:0] exp_data);
        repeat (5) tick();
        chk(int_n == 1'b0, "R6 int held low without read", int_n, 0);
        rd_n = 1'b0;
        tick(); tick();
        chk(db_oe == 1'b0, "R7 oe low before edge 3", db_oe, 0);
        tick();
        chk(db_oe == 1'b1, "R7 oe high on edge 3", db_oe, 1);
        chk(int_n == 1'b0, "R6 low read does not clear int", int_n, 0);
        chk(db_out == exp_data, "R5 data on read", db_out, exp_data);
        rd_n = 1'b1;
        tick(); tick();
        chk(int_n == 1'b0, "R6 int low before edge 3 after release", int_n, 0);
        tick();
        chk(int_n == 1'b1, "R6 int high on edge 3 after release", int_n, 1);
        chk(db_oe == 1'b0, "R7 oe low after release", db_oe, 0);
    endtask

    task automatic t_recovery();
        int bad = 0;
        sh_n = 1'b0;
        tick();
        sh_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (trk_o) bad++;
        end
        chk(bad == 0, "R10 start in recovery window ignored", bad, 0);
    endtask

    task automatic t_mode2(input logic [5:0] c, input logic [3:0] f, input logic [9:0] prev);
        int trk_n = 0;
        int fine_n = 0;
        int n = 0;
        mode_rd = 1'b1;
        coarse_code = c; fine_code = f;
        sh_n = 1'b0; rd_n = 1'b0;
        while (n < 100) begin
            tick();
            n++;
            if (trk_o) trk_n++;
            if (fine_o) begin
                fine_n++;
                coarse_code = ~c;
            end
            if (n == 5) begin
                chk(db_oe == 1'b1, "R8 bus enabled during conversion", db_oe, 1);
                chk(db_out == prev, "R8 previous result during conversion", db_out, prev);
            end
            if (!int_n) break;
        end
        chk(n == 3 + CC + FC, "R4 int timing in read-start mode", n, 3 + CC + FC);
        chk(trk_n == CC, "R4 timed coarse length", trk_n, CC);
        chk(fine_n == FC, "R11 fine length read-start", fine_n, FC);
        chk(db_out == {c, f}, "R5 result read-start", db_out, {c, f});
        fine_code = ~f;
        sh_n = 1'b1; rd_n = 1'b1;
        tick(); tick();
        chk(int_n == 1'b0, "R6 int low before edge 3 read-start", int_n, 0);
        tick();
        chk(int_n == 1'b1, "R6 int cleared by strobe release", int_n, 1);
        repeat (4) tick();
    endtask

    initial begin
        t_reset();
        t_cs_gate();
        t_mode1(6'h2A, 4'h5, 5, 1'b0);
        t_recovery();
        t_read_clear({6'h2A, 4'h5});
        t_mode1(6'h13, 4'hC, 8, 1'b1);
        t_read_clear({6'h13, 4'hC});
        // R10 start after recovery accepted
        t_mode1(6'h01, 4'h0, 3, 1'b0);
        t_read_clear({6'h01, 4'h0});
        t_mode2(6'h3F, 4'hF, {6'h01, 4'h0});
        t_mode2(6'h00, 4'h1, {6'h3F, 4'hF});
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule